// File: doc/BRIEF.md
# Brownout Status Snapshot Capture

This block sits beside a brownout protection engine. It keeps a running record of what the engine is doing, so that software can read the record later. It stores three things: the engine state as last seen, the deepest gain-reduction level engaged, and the smallest supply sample measured. A lower level index means a deeper level.

Software controls the record with a single hold bit. While the bit is low, the record follows the engine on every clock. While the bit is high, all three fields stay frozen, so a multi-access read gets one consistent picture. When software drops the bit after reading, the record starts over from the values present on that clock. The minimum of the supply therefore always covers the interval since the previous read.

Top module: `brownout_status_snap`

## Requirements
- R1: After reset, the state output is 0, the level output is the idle code 7 (no level engaged) and the supply output is 0x3FF.
- R2: On every clock edge at which the hold bit is low, the state output loads the engine state presented at that edge, so it appears one cycle later.
- R3: While the hold bit stays low, the level output becomes the numerically smaller of its current value and the live level index. Level code 7 means no level is engaged.
- R4: While the hold bit stays low, a supply sample whose valid strobe is high replaces the stored supply only if it is smaller than the stored supply.
- R5: A supply sample presented with its valid strobe low leaves the supply output unchanged.
- R6: On every clock edge at which the hold bit is high, all three outputs keep their values, whatever the engine inputs do.
- R7: On the first edge at which the hold bit is low after being high, the record restarts:
  - the level output loads the live level;
  - the state output loads the live state;
  - the supply output loads the live sample if its strobe is high, and 0x3FF otherwise.
- R8: A level index larger than the stored one (a shallower level) does not change the level output while tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snap_hold_i | input | 1 | Software hold bit: high freezes the record; a falling edge restarts it |
| eng_state_i | input | 4 | Live engine state |
| eng_level_i | input | 3 | Live engaged level index; 7 means none |
| sup_vld_i | input | 1 | Supply sample valid strobe |
| sup_sample_i | input | 10 | Supply sample |
| snap_state_o | output | 4 | Captured engine state |
| snap_level_o | output | 3 | Deepest level engaged since the last restart |
| snap_supply_o | output | 10 | Lowest valid supply sample since the last restart |

## Verification
The following relations are checked by assertions on every cycle:
- the state output follows the engine state one cycle behind while the hold bit is low;
- the level and supply outputs never exceed the live level or the valid sample that was just taken;
- the level output loads the live level when the hold bit falls;
- all outputs are stable while the hold bit is high.

Only the bench scenarios show two further properties. The first is that the exact minimum is kept across a sequence that mixes deeper, shallower and invalid inputs. The second is the choice between the live sample and 0x3FF on restart. The bench also confirms the values after a reset in the middle of a run.

// File: rtl/bss_pkg.sv
package bss_pkg;

   // Action selected for the capture registers on each clock edge
   typedef enum logic [1:0] {
      ACT_TRACK   = 2'd0,
      ACT_FREEZE  = 2'd1,
      ACT_RESTART = 2'd2
   } bss_act_e;

endpackage

// File: rtl/bss_hold_ctrl.sv
module bss_hold_ctrl
   import bss_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     hold_i,
   output bss_act_e act_o
);

   logic hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= hold_i;
   end

   // Hold high freezes; the first low cycle after a high one restarts
   always_comb begin
      if (hold_i)      act_o = ACT_FREEZE;
      else if (hold_q) act_o = ACT_RESTART;
      else             act_o = ACT_TRACK;
   end

endmodule

// File: rtl/bss_min_track.sv
module bss_min_track
   import bss_pkg::*;
#(
   parameter int unsigned W         = 10,
   parameter logic [W-1:0] INIT     = '1,
   parameter bit          HAS_VALID = 1'b1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  bss_act_e     act_i,
   input  logic         live_vld_i,
   input  logic [W-1:0] live_i,
   output logic [W-1:0] val_o
);

   if (W < 1) begin : g_bad_w
      $error("bss_min_track: W must be at least 1");
   end

   logic take;

   generate
      if (HAS_VALID) begin : g_strobed
         assign take = live_vld_i;
      end else begin : g_always
         logic unused_vld;
         assign unused_vld = live_vld_i;
         assign take       = 1'b1;
      end
   endgenerate

   logic [W-1:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q <= INIT;
      end else begin
         unique case (act_i)
            ACT_FREEZE:  val_q <= val_q;
            ACT_RESTART: val_q <= take ? live_i : INIT;
            default: begin
               if (take && (live_i < val_q)) val_q <= live_i;
            end
         endcase
      end
   end

   assign val_o = val_q;

endmodule

// File: rtl/bss_state_cap.sv
module bss_state_cap
   import bss_pkg::*;
#(
   parameter int unsigned W = 4
)(
   input  logic         clk,
   input  logic         rst_n,
   input  bss_act_e     act_i,
   input  logic [W-1:0] live_i,
   output logic [W-1:0] val_o
);

   if (W < 1) begin : g_bad_w
      $error("bss_state_cap: W must be at least 1");
   end

   logic [W-1:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  val_q <= '0;
      else if (act_i != ACT_FREEZE) val_q <= live_i;
   end

   assign val_o = val_q;

endmodule

// File: rtl/brownout_status_snap.sv
module brownout_status_snap
   import bss_pkg::*;
#(
   parameter int unsigned STATE_W  = 4,
   parameter int unsigned LEVEL_W  = 3,
   parameter int unsigned SUPPLY_W = 10
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                snap_hold_i,
   input  logic [STATE_W-1:0]  eng_state_i,
   input  logic [LEVEL_W-1:0]  eng_level_i,
   input  logic                sup_vld_i,
   input  logic [SUPPLY_W-1:0] sup_sample_i,
   output logic [STATE_W-1:0]  snap_state_o,
   output logic [LEVEL_W-1:0]  snap_level_o,
   output logic [SUPPLY_W-1:0] snap_supply_o
);

   localparam logic [LEVEL_W-1:0]  LEVEL_IDLE  = '1;
   localparam logic [SUPPLY_W-1:0] SUPPLY_INIT = '1;

   if (LEVEL_W < 2) begin : g_bad_level
      $error("brownout_status_snap: LEVEL_W must leave room for an idle code");
   end

   bss_act_e act;

   bss_hold_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_i (snap_hold_i),
      .act_o  (act)
   );

   bss_state_cap #(.W(STATE_W)) u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_i  (act),
      .live_i (eng_state_i),
      .val_o  (snap_state_o)
   );

   bss_min_track #(.W(LEVEL_W), .INIT(LEVEL_IDLE), .HAS_VALID(1'b0)) u_level (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_i      (act),
      .live_vld_i (1'b1),
      .live_i     (eng_level_i),
      .val_o      (snap_level_o)
   );

   bss_min_track #(.W(SUPPLY_W), .INIT(SUPPLY_INIT), .HAS_VALID(1'b1)) u_supply (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_i      (act),
      .live_vld_i (sup_vld_i),
      .live_i     (sup_sample_i),
      .val_o      (snap_supply_o)
   );

endmodule

// File: rtl/brownout_status_snap_chk.sv
module brownout_status_snap_chk #(
   parameter int unsigned STATE_W  = 4,
   parameter int unsigned LEVEL_W  = 3,
   parameter int unsigned SUPPLY_W = 10
)(
   input logic                clk,
   input logic                rst_n,
   input logic                snap_hold_i,
   input logic [STATE_W-1:0]  eng_state_i,
   input logic [LEVEL_W-1:0]  eng_level_i,
   input logic                sup_vld_i,
   input logic [SUPPLY_W-1:0] sup_sample_i,
   input logic [STATE_W-1:0]  snap_state_o,
   input logic [LEVEL_W-1:0]  snap_level_o,
   input logic [SUPPLY_W-1:0] snap_supply_o
);

   // R2
   state_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_hold_i |=> snap_state_o == $past(eng_state_i));

   // R3
   level_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_hold_i |=> snap_level_o <= $past(eng_level_i));

   // R4
   supply_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!snap_hold_i && sup_vld_i) |=> snap_supply_o <= $past(sup_sample_i));

   // R6
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_hold_i |=> ($stable(snap_state_o) && $stable(snap_level_o) && $stable(snap_supply_o)));

   // R7
   restart_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(snap_hold_i) |=> snap_level_o == $past(eng_level_i));

endmodule

bind brownout_status_snap brownout_status_snap_chk #(
   .STATE_W(STATE_W), .LEVEL_W(LEVEL_W), .SUPPLY_W(SUPPLY_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .snap_hold_i   (snap_hold_i),
   .eng_state_i   (eng_state_i),
   .eng_level_i   (eng_level_i),
   .sup_vld_i     (sup_vld_i),
   .sup_sample_i  (sup_sample_i),
   .snap_state_o  (snap_state_o),
   .snap_level_o  (snap_level_o),
   .snap_supply_o (snap_supply_o)
);

// File: tb/brownout_status_snap_bench.sv
module brownout_status_snap_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hold = 1'b0;
   logic [3:0] st = '0;
   logic [2:0] lv = 3'd7;
   logic       vld = 1'b0;
   logic [9:0] smp = '0;
   logic [3:0] o_st;
   logic [2:0] o_lv;
   logic [9:0] o_sup;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   brownout_status_snap u_brownout_status_snap (
      .clk           (clk),
      .rst_n         (rst_n),
      .snap_hold_i   (hold),
      .eng_state_i   (st),
      .eng_level_i   (lv),
      .sup_vld_i     (vld),
      .sup_sample_i  (smp),
      .snap_state_o  (o_st),
      .snap_level_o  (o_lv),
      .snap_supply_o (o_sup)
   );

   typedef struct packed {
      logic       hold;
      logic [3:0] st;
      logic [2:0] lv;
      logic       vld;
      logic [9:0] smp;
      logic [3:0] e_st;
      logic [2:0] e_lv;
      logic [9:0] e_sup;
   } vec_t;

   localparam int NVEC = 13;
   localparam vec_t VEC [NVEC] = '{
      // hold  st     lv     vld   smp        exp st exp lv  exp sup
      '{1'b0, 4'h3, 3'd7, 1'b1, 10'h200, 4'h3, 3'd7, 10'h200}, // R2 R4
      '{1'b0, 4'h5, 3'd2, 1'b1, 10'h250, 4'h5, 3'd2, 10'h200}, // R3 R4 larger sample kept out
      '{1'b0, 4'h6, 3'd4, 1'b0, 10'h010, 4'h6, 3'd2, 10'h200}, // R5 R8
      '{1'b0, 4'h1, 3'd0, 1'b1, 10'h180, 4'h1, 3'd0, 10'h180}, // R3 R4
      '{1'b1, 4'h9, 3'd0, 1'b1, 10'h005, 4'h1, 3'd0, 10'h180}, // R6
      '{1'b1, 4'hA, 3'd3, 1'b1, 10'h001, 4'h1, 3'd0, 10'h180}, // R6
      '{1'b0, 4'h2, 3'd5, 1'b0, 10'h000, 4'h2, 3'd5, 10'h3FF}, // R7 invalid sample
      '{1'b0, 4'h4, 3'd6, 1'b1, 10'h300, 4'h4, 3'd5, 10'h300}, // R8 R4
      '{1'b0, 4'h4, 3'd7, 1'b1, 10'h3FF, 4'h4, 3'd5, 10'h300}, // R8 R4
      '{1'b1, 4'h0, 3'd1, 1'b1, 10'h100, 4'h4, 3'd5, 10'h300}, // R6
      '{1'b0, 4'h7, 3'd3, 1'b1, 10'h123, 4'h7, 3'd3, 10'h123}, // R7 valid sample
      '{1'b0, 4'h8, 3'd3, 1'b1, 10'h000, 4'h8, 3'd3, 10'h000}, // R4 zero
      '{1'b0, 4'hF, 3'd0, 1'b1, 10'h3FF, 4'hF, 3'd0, 10'h000}  // R3 R4
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // Drive at the falling edge, let one rising edge pass, sample 1 time unit later
   task automatic step(input logic h, input logic [3:0] s, input logic [2:0] l,
                       input logic v, input logic [9:0] d);
      @(negedge clk);
      hold = h; st = s; lv = l; vld = v; smp = d;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset values
      check("R1 state", o_st, 0);
      check("R1 level", o_lv, 7);
      check("R1 supply", o_sup, 10'h3FF);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i].hold, VEC[i].st, VEC[i].lv, VEC[i].vld, VEC[i].smp);
         check($sformatf("R2/R6/R7 state vec%0d", i), o_st, VEC[i].e_st);
         check($sformatf("R3/R8/R6/R7 level vec%0d", i), o_lv, VEC[i].e_lv);
         check($sformatf("R4/R5/R6/R7 supply vec%0d", i), o_sup, VEC[i].e_sup);
      end

      // R6: long hold with busy inputs
      step(1'b1, 4'h5, 3'd1, 1'b1, 10'h001);
      for (int k = 0; k < 20; k++) begin
         step(1'b1, 4'(k), 3'(k % 7), 1'b1, 10'(k));
         check("R6 long hold state", o_st, 4'hF);
         check("R6 long hold level", o_lv, 0);
         check("R6 long hold supply", o_sup, 0);
      end

      // R7 restart with no level engaged and no valid sample
      step(1'b0, 4'hC, 3'd7, 1'b0, 10'h050);
      check("R7 restart state", o_st, 4'hC);
      check("R7 restart level idle", o_lv, 7);
      check("R7 restart supply init", o_sup, 10'h3FF);
      // R5 a run of invalid samples changes nothing
      step(1'b0, 4'hC, 3'd7, 1'b0, 10'h000);
      step(1'b0, 4'hC, 3'd7, 1'b0, 10'h001);
      check("R5 invalid ignored", o_sup, 10'h3FF);
      // R4 equal sample keeps the value
      step(1'b0, 4'hC, 3'd6, 1'b1, 10'h3FE);
      step(1'b0, 4'hC, 3'd6, 1'b1, 10'h3FE);
      check("R4 equal sample", o_sup, 10'h3FE);
      check("R3 level 6", o_lv, 6);

      // R1 reset in the middle of a run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 mid reset state", o_st, 0);
      check("R1 mid reset level", o_lv, 7);
      check("R1 mid reset supply", o_sup, 10'h3FF);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 4'h2, 3'd1, 1'b1, 10'h0AA);
      check("R2 after reset", o_st, 4'h2);
      check("R3 after reset", o_lv, 1);
      check("R4 after reset", o_sup, 10'h0AA);

      finish_run();
   end

endmodule